// File: doc/BRIEF.md
# Voice Amplitude Envelope Generator

This block shapes the loudness of one synthesizer voice. It holds a 10-bit attenuation level, where 0x3FF is silence and 0 is full volume. Once per output sample the level moves through four phases: a falling attack, a first rising decay up to a programmable sustain threshold, a second rising decay up to silence, and a release that rises to silence after the note is let go. The logic around it pulses a sample tick once per output sample, strobes key-on and key-off when a note starts or stops, and uses the attenuation output to scale the voice's samples.

Each phase has a 5-bit rate. The rate is doubled and then shifted by a key-scaling amount, by the top bit of the pitch fraction and by a signed octave. The result is clamped to 0..63 and selects a step size. The step is kept with 16 fraction bits, so slow rates move the level by a fraction of a unit per sample. Attack has its own step table, four times faster than the decay and release table. Attack can instead be held at full volume until the sample address stepper reports that the loop start has been reached. When a note's release reaches silence, the block emits a one-cycle pulse that tells the voice it may shut down.

Top module: `voice_env_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `state` is 3 (release), `atten` is 0x3FF and `chan_off` is 0.
- R2: A `key_on` strobe seen while `state` is 3 takes effect on the next cycle: `atten` is 0x3FF and `state` is 0 (attack). This applies even when `key_off` is high in the same cycle. State codes are attack=0, decay1=1, decay2=2, release=3.
- R3: A `key_on` strobe seen in states 0, 1 or 2 is ignored. Neither `state` nor `atten` changes because of it.
- R4: A `key_off` strobe in states 0, 1 or 2 moves the block to state 3 on the next cycle and leaves `atten` unchanged. A `key_off` strobe in state 3 is ignored. A key strobe that takes effect suppresses the envelope step in that cycle.
- R5: In attack, each tick subtracts the attack step. When the integer part of the result would be 0 or less, the level is set to exactly 0. With `lsl_en` low, the block enters decay1 on that same tick.
- R6: With `lsl_en` high, attack ends only on a tick that has `loop_hit` high. It ends on that tick whatever the level is. Until then the level stays clamped at 0.
- R7: In decay1, each tick adds the decay step. The block enters decay2 on the first tick that leaves `atten` at or above `dl` × 32.
- R8: In decay2, each tick adds the decay step. When the level reaches or passes 0x3FF, it is set to 0x3FF and the block enters release.
- R9: In release, each tick adds the release step, saturating at 0x3FF. The first release tick of a note that reaches 0x3FF raises `chan_off` for exactly one cycle. There is no other pulse until the next key-on. `chan_off` high always coincides with `state` 3 and `atten` 0x3FF.
- R10: The effective rate is computed as follows. Start with `krs` + `fns_msb` + 2 × rate. If `krs` is 15, subtract 15. If `oct` is 0..7, add 2 × `oct`; if `oct` is 8..15, subtract 2 × (16 − `oct`). Clamp the result to 0..63.
- R11: For effective rate e ≥ 2, the decay and release step is (4 + e mod 4) × 2^(e div 4) in units of 2^-16. The attack step is four times that value. For e = 0 or e = 1 the step is zero, which freezes the level.
- R12: On a cycle with `tick`, `key_on` and `key_off` all low, `atten` and `state` hold and `chan_off` is 0 on the next cycle. `loop_hit` alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse per output sample |
| key_on | input | 1 | Note start strobe |
| key_off | input | 1 | Note stop strobe |
| rate_atk | input | 5 | Attack rate |
| rate_dk1 | input | 5 | First decay rate |
| rate_dk2 | input | 5 | Second decay rate |
| rate_rel | input | 5 | Release rate |
| dl | input | 5 | Sustain threshold; decay1 ends at dl × 32 |
| krs | input | 4 | Key scaling amount; 15 removes its offset |
| oct | input | 4 | Signed octave, two's complement |
| fns_msb | input | 1 | Top bit of the pitch fraction |
| lsl_en | input | 1 | Hold attack until the loop start is reached |
| loop_hit | input | 1 | Address stepper reached the loop start |
| atten | output | 10 | Attenuation, 0x3FF = silent |
| state | output | 2 | Envelope phase code |
| chan_off | output | 1 | One-cycle pulse when release reaches silence |

## Verification
The properties assume that `rst` is held high from time zero through the first clock edge. They also assume that `key_on`, `key_off` and `loop_hit` are sampled as plain synchronous levels, and that `loop_hit` matters only on tick cycles. The properties hold whatever values the rate, threshold, scaling and octave inputs take.

The bench changes those configuration inputs only at reset boundaries, before a key-on. All inputs are driven at the falling clock edge. Ticks are separated by idle cycles, so that hold behaviour is exercised between steps. Simultaneous key strobes, a key-on in attack and a loop hit without a tick are applied on purpose, to reach the priority and ignore cases.

// File: rtl/voice_env_pkg.sv
package voice_env_pkg;
  typedef enum logic [1:0] {
    ENV_ATTACK  = 2'd0,
    ENV_DECAY1  = 2'd1,
    ENV_DECAY2  = 2'd2,
    ENV_RELEASE = 2'd3
  } env_state_e;
endpackage

// File: rtl/env_rate_scale.sv
module env_rate_scale #(
  parameter int RATE_W = 5,
  parameter int KRS_W  = 4,
  parameter int OCT_W  = 4,
  parameter int EFF_W  = 6
) (
  input  logic [RATE_W-1:0] rate,
  input  logic [KRS_W-1:0]  krs,
  input  logic [OCT_W-1:0]  oct,
  input  logic              fns_msb,
  output logic [EFF_W-1:0]  eff
);
  localparam int KRS_OFF  = (1 << KRS_W) - 1;
  localparam int OCT_SPAN = 1 << OCT_W;
  localparam int EFF_MAX  = (1 << EFF_W) - 1;

  // key/octave scaling of a raw phase rate, clamped to the table range
  function automatic logic [EFF_W-1:0] scale_rate(
    input logic [RATE_W-1:0] r,
    input logic [KRS_W-1:0]  k,
    input logic [OCT_W-1:0]  o,
    input logic              f
  );
    int v;
    v = int'(k) + int'(f) + 2 * int'(r);
    if (int'(k) == KRS_OFF) v = v - KRS_OFF;
    if (o[OCT_W-1]) v = v - 2 * (OCT_SPAN - int'(o));
    else            v = v + 2 * int'(o);
    if (v < 0)            v = 0;
    else if (v > EFF_MAX) v = EFF_MAX;
    return v[EFF_W-1:0];
  endfunction

  assign eff = scale_rate(rate, krs, oct, fns_msb);
endmodule

// File: rtl/env_step_rom.sv
module env_step_rom #(
  parameter int EFF_W  = 6,
  parameter int STEP_W = 28,
  parameter bit FAST   = 1'b0
) (
  input  logic [EFF_W-1:0]  eff,
  output logic [STEP_W-1:0] step
);
  // mantissa 4..7 by the two low bits, exponent by the rest
  function automatic logic [STEP_W-1:0] base_step(input logic [EFF_W-1:0] e);
    logic [STEP_W-1:0] mant;
    if (e < 2) return '0;
    mant = STEP_W'(4 + int'(e[1:0]));
    return mant << e[EFF_W-1:2];
  endfunction

  logic [STEP_W-1:0] base;
  assign base = base_step(eff);

  generate
    if (FAST) begin : g_attack
      assign step = base << 2;
    end else begin : g_decay
      assign step = base;
    end
  endgenerate
endmodule

// File: rtl/env_core.sv
module env_core
  import voice_env_pkg::*;
#(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 16,
  parameter int DL_W   = 5,
  parameter int ACC_W  = INT_W + FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              key_on,
  input  logic              key_off,
  input  logic              lsl_en,
  input  logic              loop_hit,
  input  logic [DL_W-1:0]   dl,
  input  logic [ACC_W-1:0]  step,
  output env_state_e        cur_state,
  output logic [INT_W-1:0]  atten,
  output logic              chan_off
);
  localparam int DL_SHIFT = INT_W - DL_W;
  localparam logic [ACC_W-1:0] ONE  = ACC_W'(1) << FRAC_W;
  localparam logic [ACC_W-1:0] CEIL = ACC_W'((1 << INT_W) - 1) << FRAC_W;

  env_state_e       st;
  logic [ACC_W-1:0] acc;
  logic             done;
  logic             off_q;

  // named events, also visible to the checker
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] dl_target;
  logic             atk_floor;
  logic             dk1_reached;
  logic             ceil_hit;
  logic             start_note;
  logic             stop_note;
  logic             step_en;

  assign sum         = acc + step;
  assign dl_target   = ACC_W'(dl) << (FRAC_W + DL_SHIFT);
  assign atk_floor   = {1'b0, acc} < ({1'b0, step} + {1'b0, ONE});
  assign dk1_reached = sum >= dl_target;
  assign ceil_hit    = sum >= CEIL;
  assign start_note  = key_on && (st == ENV_RELEASE);
  assign stop_note   = !start_note && key_off && (st != ENV_RELEASE);
  assign step_en     = tick && !start_note && !stop_note;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ENV_RELEASE;
      acc   <= CEIL;
      done  <= 1'b1;
      off_q <= 1'b0;
    end else begin
      off_q <= 1'b0;
      if (start_note) begin
        st   <= ENV_ATTACK;
        acc  <= CEIL;
        done <= 1'b0;
      end else if (stop_note) begin
        st <= ENV_RELEASE;
      end else if (step_en) begin
        unique case (st)
          ENV_ATTACK: begin
            acc <= atk_floor ? '0 : acc - step;
            if (lsl_en ? loop_hit : atk_floor) st <= ENV_DECAY1;
          end
          ENV_DECAY1: begin
            acc <= sum;
            if (dk1_reached) st <= ENV_DECAY2;
          end
          ENV_DECAY2: begin
            if (ceil_hit) begin
              acc <= CEIL;
              st  <= ENV_RELEASE;
            end else begin
              acc <= sum;
            end
          end
          ENV_RELEASE: begin
            if (ceil_hit) begin
              acc <= CEIL;
              if (!done) begin
                off_q <= 1'b1;
                done  <= 1'b1;
              end
            end else begin
              acc <= sum;
            end
          end
        endcase
      end
    end
  end

  assign cur_state = st;
  assign atten     = (|acc[ACC_W-1:FRAC_W+INT_W]) ? '1 : acc[FRAC_W +: INT_W];
  assign chan_off  = off_q;
endmodule

// File: rtl/voice_env_gen.sv
module voice_env_gen
  import voice_env_pkg::*;
#(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 16,
  parameter int RATE_W = 5,
  parameter int DL_W   = 5,
  parameter int KRS_W  = 4,
  parameter int OCT_W  = 4,
  parameter int EFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              key_on,
  input  logic              key_off,
  input  logic [RATE_W-1:0] rate_atk,
  input  logic [RATE_W-1:0] rate_dk1,
  input  logic [RATE_W-1:0] rate_dk2,
  input  logic [RATE_W-1:0] rate_rel,
  input  logic [DL_W-1:0]   dl,
  input  logic [KRS_W-1:0]  krs,
  input  logic [OCT_W-1:0]  oct,
  input  logic              fns_msb,
  input  logic              lsl_en,
  input  logic              loop_hit,
  output logic [INT_W-1:0]  atten,
  output logic [1:0]        state,
  output logic              chan_off
);
  localparam int ACC_W = INT_W + FRAC_W + 2;

  env_state_e        cur_state;
  logic [RATE_W-1:0] sel_rate;
  logic [EFF_W-1:0]  eff_rate;
  logic [ACC_W-1:0]  atk_step;
  logic [ACC_W-1:0]  dsr_step;
  logic [ACC_W-1:0]  step_sel;

  always_comb begin
    unique case (cur_state)
      ENV_ATTACK: sel_rate = rate_atk;
      ENV_DECAY1: sel_rate = rate_dk1;
      ENV_DECAY2: sel_rate = rate_dk2;
      default:    sel_rate = rate_rel;
    endcase
  end

  env_rate_scale #(
    .RATE_W(RATE_W), .KRS_W(KRS_W), .OCT_W(OCT_W), .EFF_W(EFF_W)
  ) u_scale (
    .rate(sel_rate), .krs(krs), .oct(oct), .fns_msb(fns_msb), .eff(eff_rate)
  );

  env_step_rom #(.EFF_W(EFF_W), .STEP_W(ACC_W), .FAST(1'b1)) u_atk_rom (
    .eff(eff_rate), .step(atk_step)
  );

  env_step_rom #(.EFF_W(EFF_W), .STEP_W(ACC_W), .FAST(1'b0)) u_dsr_rom (
    .eff(eff_rate), .step(dsr_step)
  );

  assign step_sel = (cur_state == ENV_ATTACK) ? atk_step : dsr_step;

  env_core #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .DL_W(DL_W), .ACC_W(ACC_W)
  ) u_core (
    .clk(clk), .rst(rst), .tick(tick), .key_on(key_on), .key_off(key_off),
    .lsl_en(lsl_en), .loop_hit(loop_hit), .dl(dl), .step(step_sel),
    .cur_state(cur_state), .atten(atten), .chan_off(chan_off)
  );

  assign state = cur_state;
endmodule

// File: rtl/voice_env_chk.sv
module voice_env_chk #(
  parameter int INT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             key_on,
  input logic             key_off,
  input logic             lsl_en,
  input logic             loop_hit,
  input logic [INT_W-1:0] atten,
  input logic [1:0]       state,
  input logic             chan_off
);
  localparam logic [INT_W-1:0] SILENT = '1;

  assert_reset_release_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (state == 2'd3 && atten == SILENT && !chan_off));

  assert_keyon_attack_R2: assert property (@(posedge clk) disable iff (rst)
    (key_on && state == 2'd3) |=> (state == 2'd0 && atten == SILENT));

  assert_keyon_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (key_on && !key_off && !tick && state != 2'd3) |=> ($stable(state) && $stable(atten)));

  assert_keyoff_release_R4: assert property (@(posedge clk) disable iff (rst)
    (key_off && state != 2'd3) |=> (state == 2'd3 && $stable(atten)));

  assert_floor_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !key_off && !lsl_en && state == 2'd0 && atten == '0) |=> (state == 2'd1));

  assert_link_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !key_off && lsl_en && !loop_hit && state == 2'd0) |=> (state == 2'd0));

  assert_link_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !key_off && lsl_en && loop_hit && state == 2'd0) |=> (state == 2'd1));

  assert_off_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    chan_off |-> (state == 2'd3 && atten == SILENT));

  assert_off_single_R9: assert property (@(posedge clk) disable iff (rst)
    chan_off |=> !chan_off);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!tick && !key_on && !key_off) |=> ($stable(atten) && $stable(state) && !chan_off));
endmodule

bind voice_env_gen voice_env_chk #(.INT_W(INT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .key_on(key_on), .key_off(key_off),
  .lsl_en(lsl_en), .loop_hit(loop_hit), .atten(atten), .state(state),
  .chan_off(chan_off)
);

// File: tb/sim_voice_env_gen.sv
module sim_voice_env_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, key_on = 1'b0, key_off = 1'b0, loop_hit = 1'b0;
  logic [4:0] ar = '0, d1r = '0, d2r = '0, rr = '0, dl = '0;
  logic [3:0] krs = '0, oct = '0;
  logic fns_msb = 1'b0, lsl_en = 1'b0;
  logic [9:0] atten;
  logic [1:0] state;
  logic chan_off;

  int n_chk = 0;
  int n_fail = 0;

  // behavioural reference
  longint m_acc;
  int m_st, m_done, m_off;
  string m_req;
  longint atk_tab[64];
  longint dsr_tab[64];

  always #5 clk = ~clk;

  voice_env_gen u0 (
    .clk(clk), .rst(rst), .tick(tick), .key_on(key_on), .key_off(key_off),
    .rate_atk(ar), .rate_dk1(d1r), .rate_dk2(d2r), .rate_rel(rr), .dl(dl),
    .krs(krs), .oct(oct), .fns_msb(fns_msb), .lsl_en(lsl_en),
    .loop_hit(loop_hit), .atten(atten), .state(state), .chan_off(chan_off)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_of(input int raw);
    int o, v;
    o = (oct > 7) ? int'(oct) - 16 : int'(oct);
    v = int'(krs) + int'(fns_msb) + raw * 2 + o * 2;
    if (krs == 4'd15) v = v - 15;
    if (v < 0) v = 0;
    if (v > 63) v = 63;
    return v;
  endfunction

  task automatic model_reset();
    m_acc = 1023 * 65536; m_st = 3; m_done = 1; m_off = 0; m_req = "R1";
  endtask

  task automatic model_step(input bit t, input bit kon, input bit koff, input bit hit);
    longint s;
    m_off = 0;
    if (kon && m_st == 3) begin
      m_st = 0; m_acc = 1023 * 65536; m_done = 0; m_req = "R2";
    end else if (koff && m_st != 3) begin
      m_st = 3; m_req = "R4";
    end else if (t) begin
      case (m_st)
        0: begin
          s = atk_tab[eff_of(int'(ar))];
          if (m_acc - s < 65536) m_acc = 0; else m_acc = m_acc - s;
          if (lsl_en) begin
            if (hit) m_st = 1;
            m_req = "R6";
          end else begin
            if (m_acc == 0) m_st = 1;
            m_req = "R5";
          end
        end
        1: begin
          m_acc = m_acc + dsr_tab[eff_of(int'(d1r))];
          if ((m_acc >> 16) >= longint'(dl) * 32) m_st = 2;
          m_req = "R7";
        end
        2: begin
          m_acc = m_acc + dsr_tab[eff_of(int'(d2r))];
          if ((m_acc >> 16) >= 1023) begin m_acc = 1023 * 65536; m_st = 3; end
          m_req = "R8";
        end
        default: begin
          m_acc = m_acc + dsr_tab[eff_of(int'(rr))];
          if ((m_acc >> 16) >= 1023) begin
            m_acc = 1023 * 65536;
            if (m_done == 0) begin m_off = 1; m_done = 1; end
          end
          m_req = "R9";
        end
      endcase
    end else begin
      m_req = "R12";
    end
  endtask

  // one clock: drive at the falling edge, compare at the next falling edge
  task automatic cyc(input bit t, input bit kon, input bit koff, input bit hit);
    tick = t; key_on = kon; key_off = koff; loop_hit = hit;
    model_step(t, kon, koff, hit);
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; key_on = 1'b0; key_off = 1'b0; loop_hit = 1'b0;
    chk(longint'(atten) == (m_acc >> 16), m_req, "model atten", atten, m_acc >> 16);
    chk(int'(state) == m_st, m_req, "model state", state, m_st);
    chk(int'(chan_off) == m_off, m_req, "model chan_off", chan_off, m_off);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    model_reset();
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    ar = '0; d1r = '0; d2r = '0; rr = '0; dl = '0;
    krs = '0; oct = '0; fns_msb = 1'b0; lsl_en = 1'b0;
    rst = 1'b0;
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL R12 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [9:0] held;
    for (int r = 0; r < 64; r++) begin
      dsr_tab[r] = (r < 2) ? 0 : longint'(4 + r % 4) * (longint'(1) << (r / 4));
      atk_tab[r] = dsr_tab[r] * 4;
    end
    model_reset();
    @(negedge clk);
    do_reset();

    // R1 reset state, idle release ticks give no pulse
    chk(state == 2'd3 && atten == 10'h3FF && !chan_off, "R1", "reset state",
        {state, atten}, {2'd3, 10'h3FF});
    cyc(1, 0, 0, 0);
    chk(!chan_off, "R9", "no pulse without a note", chan_off, 0);

    // full note
    ar = 5'd31; d1r = 5'd28; dl = 5'd4; d2r = 5'd31; rr = 5'd31;
    cyc(0, 1, 0, 0);
    chk(state == 2'd0 && atten == 10'h3FF, "R2", "key-on enters attack", atten, 1023);
    cyc(1, 0, 0, 0);
    chk(atten == 10'd1011, "R11", "attack step at rate 62", atten, 1011);
    cyc(0, 1, 0, 0);
    chk(state == 2'd0 && atten == 10'd1011, "R3", "key-on in attack ignored", atten, 1011);
    run(85);
    chk(state == 2'd1 && atten == 10'd0, "R5", "attack floor to decay1", {state, atten}, {2'd1, 10'd0});
    run(20);
    held = atten;
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
    chk(atten == held && state == 2'd1, "R12", "no change without tick", atten, held);
    run(108);
    chk(state == 2'd2 && atten == 10'd128, "R7", "decay1 ends at dl*32", {state, atten}, {2'd2, 10'd128});
    run(298);
    chk(state == 2'd2 && atten == 10'd1022, "R8", "decay2 below ceiling", atten, 1022);
    run(1);
    chk(state == 2'd3 && atten == 10'h3FF, "R8", "decay2 clamps into release", {state, atten}, {2'd3, 10'h3FF});
    cyc(1, 0, 0, 0);
    chk(chan_off, "R9", "disable pulse", chan_off, 1);
    cyc(1, 0, 0, 0);
    chk(!chan_off, "R9", "single pulse", chan_off, 0);

    // key-off from decay1, release to silence
    do_reset();
    ar = 5'd31; d1r = 5'd28; dl = 5'd20; rr = 5'd20;
    cyc(0, 1, 0, 0);
    run(96);
    chk(state == 2'd1 && atten == 10'd10, "R7", "decay1 progress", atten, 10);
    cyc(0, 0, 1, 0);
    chk(state == 2'd3 && atten == 10'd10, "R4", "key-off to release", {state, atten}, {2'd3, 10'd10});
    cyc(0, 0, 1, 0);
    chk(state == 2'd3 && atten == 10'd10, "R4", "key-off in release ignored", atten, 10);
    rr = 5'd31;
    run(336);
    cyc(1, 0, 0, 0);
    chk(!chan_off && atten == 10'd1021, "R9", "release below ceiling", atten, 1021);
    cyc(1, 0, 0, 0);
    chk(chan_off && atten == 10'h3FF, "R9", "release reaches silence", atten, 1023);

    // loop-start link hold
    do_reset();
    lsl_en = 1'b1; ar = 5'd31;
    cyc(0, 1, 0, 0);
    run(100);
    chk(state == 2'd0 && atten == 10'd0, "R6", "attack held at zero", {state, atten}, {2'd0, 10'd0});
    cyc(1, 0, 0, 1);
    chk(state == 2'd1 && atten == 10'd0, "R6", "loop hit ends attack", state, 1);
    do_reset();
    lsl_en = 1'b1; ar = 5'd31;
    cyc(0, 1, 0, 0);
    run(5);
    cyc(0, 0, 0, 1);
    chk(state == 2'd0 && atten == 10'd963, "R12", "loop hit without tick", atten, 963);
    cyc(1, 0, 0, 1);
    chk(state == 2'd1 && atten == 10'd951, "R6", "early loop hit", {state, atten}, {2'd1, 10'd951});

    // simultaneous strobes
    do_reset();
    cyc(0, 1, 1, 0);
    chk(state == 2'd0 && atten == 10'h3FF, "R2", "key-on wins in release", state, 0);
    cyc(0, 1, 1, 0);
    chk(state == 2'd3, "R4", "key-off wins outside release", state, 3);

    // effective rate scaling
    do_reset();
    ar = 5'd20; oct = 4'd14;
    cyc(0, 1, 0, 0); run(16);
    chk(atten == 10'd1021, "R10", "negative octave", atten, 1021);
    do_reset();
    ar = 5'd25; krs = 4'd15; fns_msb = 1'b1;
    cyc(0, 1, 0, 0); run(4);
    chk(atten == 10'd1016, "R10", "full key scaling code", atten, 1016);
    do_reset();
    ar = 5'd31; oct = 4'd7;
    cyc(0, 1, 0, 0); run(1);
    chk(atten == 10'd1009, "R10", "upper clamp", atten, 1009);
    do_reset();
    ar = 5'd0;
    cyc(0, 1, 0, 0); run(10);
    chk(state == 2'd0 && atten == 10'h3FF, "R11", "rate zero freezes", atten, 1023);
    do_reset();
    ar = 5'd1; oct = 4'd8;
    cyc(0, 1, 0, 0); run(10);
    chk(state == 2'd0 && atten == 10'h3FF, "R10", "lower clamp freezes", atten, 1023);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule